// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits behind the four-wire SPI pins of a serial flash device and turns the bit stream into command events. It runs on the chip's system clock and oversamples chip select, serial clock and serial data in through synchronizers. It then finds the serial clock edges and shifts in an 8-bit opcode and the address or dummy bytes that follow it. It keeps two permission flags: a write-enable latch, and a separate permission that allows one status write to the volatile copy of the status bits.

When chip select rises at the end of a well-formed program, erase, status-write or security-register command, the block emits a one-cycle strobe. The strobe carries the command kind, the captured 24-bit address and a gate bit that says whether the command may execute. The memory array and the real write timing sit downstream and take the strobe. The identification commands are answered here. The block shifts ID bytes out on the falling serial clock edge, most significant bit first, and repeats the sequence until chip select rises. Clock polarity may idle low or high, so both SPI mode 0 and mode 3 work.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset the write-enable latch and the volatile-status permission read 0, the data-out enable is 0 and no command strobe is issued.
- R2: Data in is taken on rising serial clock edges while chip select is low, and data out changes on falling edges, most significant bit first. This holds whether the clock idles low (mode 0) or high (mode 3).
- R3: Opcode 06h sets the write-enable latch when chip select rises after exactly one whole byte. Any other byte count leaves the latch unchanged.
- R4: Opcode 50h, sent as exactly one byte, sets the volatile-status permission. A status write (01h, at least one data byte) is allowed when the write-enable latch or that permission is set, and an allowed status write clears both.
- R5: At the chip-select rise of a complete, byte-aligned gated command, `cmd_stb` pulses for one cycle with `cmd_kind` set as follows. 1 is page program 02h (5 or more bytes). 2 is sector erase 20h (4 or more bytes). 3 is block erase D8h (4 or more bytes). 4 is chip erase C7h (exactly 1 byte). 5 is status write 01h (2 or more bytes). 6 is security erase 44h (4 or more bytes). 7 is security program 42h (5 or more bytes). `cmd_addr` holds the first three bytes after the opcode, first byte in bits 23:16.
- R6: Every gated command other than a status write is allowed only when the write-enable latch is 1. An allowed command clears the latch, and a refused one leaves it as it was.
- R7: Opcode 9Fh returns manufacturer ID, memory type and capacity, in that order, and repeats them until chip select rises.
- R8: Opcode 90h returns the manufacturer ID and then the device ID, repeating, after three address bytes.
- R9: Opcode ABh returns the device ID byte, repeating, after three dummy bytes.
- R10: Opcode 4Bh returns the 64-bit unique ID, most significant byte first and repeating, after four dummy bytes.
- R11: For security commands, `sec_sel` is 1, 2 or 3 when address bits 23:16 are 00h and bits 15:8 are 10h, 20h or 30h respectively. For any other address it is 0 and the command is refused. For other kinds it is 0.
- R12: `spi_miso_oe` is 0 while chip select is high, and also during the opcode and prefix bytes of an ID command.
- R13: An unknown opcode, or a gated command with too few bytes or a partial last byte, produces no strobe, no data out and no change to either permission flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out |
| spi_miso_oe | output | 1 | Drive enable for data out (0 = high impedance) |
| wel | output | 1 | Write-enable latch |
| vsr_wen | output | 1 | Volatile-status write permission |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command kind code for the strobe (R5) |
| cmd_allowed | output | 1 | Gate: the strobed command may execute |
| cmd_addr | output | 24 | Address bytes captured for the strobed command |
| sec_sel | output | 2 | Security register number 1..3, or 0 |

## Verification
A wrong bit or byte counter shows at the ports within the same transaction. The ID bytes come out shifted or from the wrong position in the sequence, or the drive enable rises during a prefix byte. A gated command's strobe also goes missing or carries the wrong kind. A corrupted permission flag stays hidden until the next gated command. The bench therefore follows every latch-setting or latch-clearing step with a command whose gate bit exposes the latch's value. It also reads `wel` and `vsr_wen` straight after each chip-select rise. The repeat behaviour is checked by reading one byte past the end of each ID sequence, and part of the traffic runs in mode 3.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    typedef enum logic [2:0] {
        K_NONE       = 3'd0,
        K_PAGE_PROG  = 3'd1,
        K_SECT_ERASE = 3'd2,
        K_BLK_ERASE  = 3'd3,
        K_CHIP_ERASE = 3'd4,
        K_WR_STATUS  = 3'd5,
        K_SEC_ERASE  = 3'd6,
        K_SEC_PROG   = 3'd7
    } cmd_kind_e;

    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_VSR_WEN  = 8'h50;
    localparam logic [7:0] OP_WRSR     = 8'h01;
    localparam logic [7:0] OP_PP       = 8'h02;
    localparam logic [7:0] OP_SE       = 8'h20;
    localparam logic [7:0] OP_BE       = 8'hD8;
    localparam logic [7:0] OP_CE       = 8'hC7;
    localparam logic [7:0] OP_SEC_ER   = 8'h44;
    localparam logic [7:0] OP_SEC_PR   = 8'h42;
    localparam logic [7:0] OP_JID      = 8'h9F;
    localparam logic [7:0] OP_MID      = 8'h90;
    localparam logic [7:0] OP_DID      = 8'hAB;
    localparam logic [7:0] OP_UID      = 8'h4B;

endpackage

// File: rtl/fcf_pin_sync.sv
module fcf_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_low,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi
);
    localparam int W = STAGES + 1;

    logic [W-1:0] cs_q, sck_q, mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            cs_q   <= {cs_q[W-2:0], cs_n_i};
            sck_q  <= {sck_q[W-2:0], sck_i};
            mosi_q <= {mosi_q[W-2:0], mosi_i};
        end
    end

    assign cs_low   = ~cs_q[W-2];
    assign cs_fall  = ~cs_q[W-2] &  cs_q[W-1];
    assign cs_rise  =  cs_q[W-2] & ~cs_q[W-1];
    assign sck_rise =  sck_q[W-2] & ~sck_q[W-1];
    assign sck_fall = ~sck_q[W-2] &  sck_q[W-1];
    assign mosi     =  mosi_q[W-2] & ~mosi_q[W-1] | mosi_q[W-2] & mosi_q[W-1];

endmodule

// File: rtl/fcf_op_decode.sv
module fcf_op_decode
    import fcf_pkg::*;
(
    input  logic [7:0]  op,
    output cmd_kind_e   kind,
    output logic [3:0]  need_bytes,
    output logic        need_exact,
    output logic        is_wren,
    output logic        is_vsr,
    output logic        is_id,
    output logic [2:0]  id_prefix,
    output logic [3:0]  id_len
);
    always_comb begin
        kind       = K_NONE;
        need_bytes = 4'd0;
        need_exact = 1'b0;
        is_wren    = (op == OP_WREN);
        is_vsr     = (op == OP_VSR_WEN);
        is_id      = 1'b0;
        id_prefix  = 3'd0;
        id_len     = 4'd1;
        case (op)
            OP_PP:     begin kind = K_PAGE_PROG;  need_bytes = 4'd5; end
            OP_SE:     begin kind = K_SECT_ERASE; need_bytes = 4'd4; end
            OP_BE:     begin kind = K_BLK_ERASE;  need_bytes = 4'd4; end
            OP_CE:     begin kind = K_CHIP_ERASE; need_bytes = 4'd1; need_exact = 1'b1; end
            OP_WRSR:   begin kind = K_WR_STATUS;  need_bytes = 4'd2; end
            OP_SEC_ER: begin kind = K_SEC_ERASE;  need_bytes = 4'd4; end
            OP_SEC_PR: begin kind = K_SEC_PROG;   need_bytes = 4'd5; end
            OP_JID:    begin is_id = 1'b1; id_prefix = 3'd0; id_len = 4'd3; end
            OP_MID:    begin is_id = 1'b1; id_prefix = 3'd3; id_len = 4'd2; end
            OP_DID:    begin is_id = 1'b1; id_prefix = 3'd3; id_len = 4'd1; end
            OP_UID:    begin is_id = 1'b1; id_prefix = 3'd4; id_len = 4'd8; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import fcf_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          CNT_W       = 8,
    parameter logic [7:0]  MFR_ID      = 8'h5E,
    parameter logic [7:0]  MEM_TYPE    = 8'h40,
    parameter logic [7:0]  CAPACITY    = 8'h14,
    parameter logic [7:0]  DEV_ID      = 8'h13,
    parameter logic [63:0] UNIQUE_ID   = 64'h0123_4567_89AB_CDEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    output logic        wel,
    output logic        vsr_wen,
    output logic        cmd_stb,
    output logic [2:0]  cmd_kind,
    output logic        cmd_allowed,
    output logic [23:0] cmd_addr,
    output logic [1:0]  sec_sel
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [2:0]       bit_ph;
        logic [CNT_W-1:0] byte_cnt;
        logic [7:0]       shreg;
        logic [7:0]       opcode;
        logic [23:0]      addr;
        logic [2:0]       out_bit;
        logic [2:0]       out_byte;
        logic             miso;
        logic             oe;
        logic             wel;
        logic             vsr;
        logic             stb;
        cmd_kind_e        kind;
        logic             allowed;
        logic [23:0]      addr_o;
        logic [1:0]       sec;
    } fe_state_t;

    fe_state_t st_d, st_q;

    logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;

    fcf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (spi_cs_n),
        .sck_i   (spi_sck),
        .mosi_i  (spi_mosi),
        .cs_low  (cs_low),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .mosi    (mosi_s)
    );

    cmd_kind_e  dec_kind;
    logic [3:0] dec_need;
    logic       dec_exact, dec_wren, dec_vsr, dec_id;
    logic [2:0] dec_pre;
    logic [3:0] dec_len;

    fcf_op_decode u_dec (
        .op        (st_q.opcode),
        .kind      (dec_kind),
        .need_bytes(dec_need),
        .need_exact(dec_exact),
        .is_wren   (dec_wren),
        .is_vsr    (dec_vsr),
        .is_id     (dec_id),
        .id_prefix (dec_pre),
        .id_len    (dec_len)
    );

    // security register page decode from the captured address
    logic [1:0] sec_page;
    always_comb begin
        sec_page = 2'd0;
        if (st_q.addr[23:16] == 8'h00) begin
            case (st_q.addr[15:8])
                8'h10:   sec_page = 2'd1;
                8'h20:   sec_page = 2'd2;
                8'h30:   sec_page = 2'd3;
                default: sec_page = 2'd0;
            endcase
        end
    end

    // ID byte at the current output position
    logic [63:0] uid_sh;
    logic [7:0]  id_byte;
    always_comb begin
        uid_sh = UNIQUE_ID >> {(3'd7 - st_q.out_byte), 3'b000};
        case (st_q.opcode)
            OP_JID:  id_byte = (st_q.out_byte == 3'd0) ? MFR_ID :
                               (st_q.out_byte == 3'd1) ? MEM_TYPE : CAPACITY;
            OP_MID:  id_byte = (st_q.out_byte == 3'd0) ? MFR_ID : DEV_ID;
            OP_DID:  id_byte = DEV_ID;
            default: id_byte = uid_sh[7:0];
        endcase
    end

    logic is_sec_kind, complete, gate_ok;
    always_comb begin
        is_sec_kind = (dec_kind == K_SEC_ERASE) || (dec_kind == K_SEC_PROG);
        complete    = (st_q.bit_ph == 3'd0) && (dec_kind != K_NONE) &&
                      (dec_exact ? (st_q.byte_cnt == CNT_W'(dec_need))
                                 : (st_q.byte_cnt >= CNT_W'(dec_need)));
        if (dec_kind == K_WR_STATUS)
            gate_ok = st_q.wel | st_q.vsr;
        else if (is_sec_kind)
            gate_ok = st_q.wel && (sec_page != 2'd0);
        else
            gate_ok = st_q.wel;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (cs_fall) begin
            st_d.bit_ph   = 3'd0;
            st_d.byte_cnt = '0;
            st_d.opcode   = 8'h00;
            st_d.addr     = 24'h0;
            st_d.out_bit  = 3'd0;
            st_d.out_byte = 3'd0;
            st_d.oe       = 1'b0;
        end else if (cs_rise) begin
            if (st_q.bit_ph == 3'd0 && st_q.byte_cnt == CNT_W'(1)) begin
                if (dec_wren) st_d.wel = 1'b1;
                if (dec_vsr)  st_d.vsr = 1'b1;
            end
            if (complete) begin
                st_d.stb     = 1'b1;
                st_d.kind    = dec_kind;
                st_d.allowed = gate_ok;
                st_d.addr_o  = st_q.addr;
                st_d.sec     = is_sec_kind ? sec_page : 2'd0;
                if (gate_ok) begin
                    st_d.wel = 1'b0;
                    if (dec_kind == K_WR_STATUS) st_d.vsr = 1'b0;
                end
            end
        end else if (cs_low) begin
            if (sck_rise) begin
                st_d.shreg  = {st_q.shreg[6:0], mosi_s};
                st_d.bit_ph = st_q.bit_ph + 3'd1;
                if (st_q.byte_cnt >= CNT_W'(1) && st_q.byte_cnt <= CNT_W'(3))
                    st_d.addr = {st_q.addr[22:0], mosi_s};
                if (st_q.bit_ph == 3'd7) begin
                    if (st_q.byte_cnt != CNT_MAX)
                        st_d.byte_cnt = st_q.byte_cnt + 1'b1;
                    if (st_q.byte_cnt == '0)
                        st_d.opcode = {st_q.shreg[6:0], mosi_s};
                end
            end
            if (sck_fall && dec_id && st_q.byte_cnt >= CNT_W'(dec_pre) + CNT_W'(1)) begin
                st_d.oe      = 1'b1;
                st_d.miso    = id_byte[3'd7 - st_q.out_bit];
                st_d.out_bit = st_q.out_bit + 3'd1;
                if (st_q.out_bit == 3'd7)
                    st_d.out_byte = ({1'b0, st_q.out_byte} == dec_len - 4'd1)
                                    ? 3'd0 : st_q.out_byte + 3'd1;
            end
        end
        if (!cs_low) st_d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso    = st_q.miso;
    assign spi_miso_oe = st_q.oe;
    assign wel         = st_q.wel;
    assign vsr_wen     = st_q.vsr;
    assign cmd_stb     = st_q.stb;
    assign cmd_kind    = st_q.kind;
    assign cmd_allowed = st_q.allowed;
    assign cmd_addr    = st_q.addr_o;
    assign sec_sel     = st_q.sec;

    // R12: data out released whenever chip select is seen high
    a_r12_oe_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !spi_miso_oe);

    // R2: output drive starts only on a falling serial clock edge
    a_r2_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(sck_fall));

    // R3: latch can only be set at a chip-select rise
    a_r3_wel_set_at_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));

    // R6: an allowed gated command leaves the latch cleared
    a_r6_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_allowed) |-> !wel);

    // R5: strobe lasts one cycle and always carries a kind
    a_r5_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    a_r5_stb_kind: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (cmd_kind != 3'd0));

    // R11: allowed security commands always name a register
    a_r11_sec_named: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_allowed && (cmd_kind == 3'd6 || cmd_kind == 3'd7)) |-> (sec_sel != 2'd0));

endmodule

// File: tb/flash_cmd_frontend_tb.sv
module flash_cmd_frontend_tb_top;

    localparam time HALF = 160ns;
    localparam logic [7:0]  MFR  = 8'h5E;
    localparam logic [7:0]  TYP  = 8'h40;
    localparam logic [7:0]  CAP  = 8'h14;
    localparam logic [7:0]  DEV  = 8'h13;
    localparam logic [63:0] UID  = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe, wel, vsr_wen, cmd_stb, cmd_allowed;
    logic [2:0]  cmd_kind;
    logic [23:0] cmd_addr;
    logic [1:0]  sec_sel;

    always #10ns clk = ~clk;

    flash_cmd_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wel(wel), .vsr_wen(vsr_wen), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
        .cmd_allowed(cmd_allowed), .cmd_addr(cmd_addr), .sec_sel(sec_sel)
    );

    int n_chk = 0, n_fail = 0;
    bit mode3 = 1'b0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    int          stb_cnt = 0;
    logic [2:0]  l_kind;
    logic        l_allowed;
    logic [23:0] l_addr;
    logic [1:0]  l_sec;

    always @(posedge clk) begin
        if (rst_n && cmd_stb) begin
            stb_cnt   <= stb_cnt + 1;
            l_kind    <= cmd_kind;
            l_allowed <= cmd_allowed;
            l_addr    <= cmd_addr;
            l_sec     <= sec_sel;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_begin();
        spi_sck = mode3;
        #(HALF);
        spi_cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic cs_end();
        if (!mode3) spi_sck = 1'b0;
        #(HALF);
        spi_cs_n = 1'b1;
        #(HALF);
        #(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_sck  = 1'b0;
            spi_mosi = tx[i];
            #(HALF);
            rx[i] = spi_miso;
            if (spi_miso_oe) oe_seen = 1'b1;
            spi_sck = 1'b1;
            #(HALF);
        end
    endtask

    task automatic send(input int n, input logic [7:0] b0, b1, b2, b3, b4);
        logic [39:0] all;
        logic [7:0]  rx;
        all = {b0, b1, b2, b3, b4};
        cs_begin();
        for (int k = 0; k < n; k++) xfer(all[39-8*k -: 8], rx);
        cs_end();
    endtask

    task automatic id_read(input string req, input logic [7:0] op, input int npre,
                           input int nout, input logic [127:0] exp);
        logic [7:0] rx;
        cs_begin();
        oe_seen = 1'b0;
        xfer(op, rx);
        for (int k = 0; k < npre; k++) xfer(8'h00, rx);
        check({req, " R12 oe low in prefix"}, 64'(oe_seen), 64'd0);
        for (int k = 0; k < nout; k++) begin
            xfer(8'h00, rx);
            check({req, " byte"}, 64'(rx), 64'(exp[127-8*k -: 8]));
        end
        check({req, " R12 oe high in data"}, 64'(spi_miso_oe), 64'd1);
        cs_end();
        check({req, " R12 oe low after cs"}, 64'(spi_miso_oe), 64'd0);
    endtask

    task automatic t_reset();
        check("R1 wel", 64'(wel), 64'd0);
        check("R1 vsr", 64'(vsr_wen), 64'd0);
        check("R1 oe", 64'(spi_miso_oe), 64'd0);
        check("R1 no strobe", 64'(stb_cnt), 64'd0);
    endtask

    task automatic t_id_reads();
        id_read("R7 jedec id", 8'h9F, 0, 4, {MFR, TYP, CAP, MFR, 96'h0});
        id_read("R8 mfr/dev id", 8'h90, 3, 3, {MFR, DEV, MFR, 104'h0});
        mode3 = 1'b1;
        id_read("R9 R2 dev id mode3", 8'hAB, 3, 2, {DEV, DEV, 112'h0});
        id_read("R10 R2 unique id mode3", 8'h4B, 4, 9, {UID, UID[63:56], 56'h0});
        mode3 = 1'b0;
    endtask

    task automatic t_wren();
        send(2, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        check("R3 wren two bytes ignored", 64'(wel), 64'd0);
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        check("R3 wren sets latch", 64'(wel), 64'd1);
    endtask

    task automatic t_erase();
        int c0;
        // latch is set from t_wren
        c0 = stb_cnt;
        send(4, 8'h20, 8'h01, 8'h23, 8'h45, 8'h00);
        check("R5 sector erase strobe", 64'(stb_cnt - c0), 64'd1);
        check("R5 sector erase kind", 64'(l_kind), 64'd2);
        check("R5 sector erase addr", 64'(l_addr), 64'h012345);
        check("R6 allowed with latch", 64'(l_allowed), 64'd1);
        check("R6 latch cleared", 64'(wel), 64'd0);
        c0 = stb_cnt;
        send(4, 8'hD8, 8'h02, 8'h00, 8'h00, 8'h00);
        check("R5 block erase strobe", 64'(stb_cnt - c0), 64'd1);
        check("R5 block erase kind", 64'(l_kind), 64'd3);
        check("R6 refused without latch", 64'(l_allowed), 64'd0);
        c0 = stb_cnt;
        send(3, 8'h20, 8'h01, 8'h23, 8'h00, 8'h00);
        check("R13 short erase no strobe", 64'(stb_cnt - c0), 64'd0);
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        c0 = stb_cnt;
        send(4, 8'h02, 8'h00, 8'h10, 8'h00, 8'h00);
        check("R13 program without data no strobe", 64'(stb_cnt - c0), 64'd0);
        check("R13 latch kept", 64'(wel), 64'd1);
        mode3 = 1'b1;
        send(5, 8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h55);
        check("R5 R2 page program mode3 kind", 64'(l_kind), 64'd1);
        check("R5 R2 page program mode3 addr", 64'(l_addr), 64'hABCDEF);
        check("R6 page program allowed", 64'(l_allowed), 64'd1);
        mode3 = 1'b0;
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        send(1, 8'hC7, 8'h00, 8'h00, 8'h00, 8'h00);
        check("R5 chip erase kind", 64'(l_kind), 64'd4);
        check("R6 chip erase allowed", 64'(l_allowed), 64'd1);
    endtask

    task automatic t_wrsr();
        send(2, 8'h01, 8'h3C, 8'h00, 8'h00, 8'h00);
        check("R4 status write refused", 64'(l_allowed), 64'd0);
        check("R4 status write kind", 64'(l_kind), 64'd5);
        send(1, 8'h50, 8'h00, 8'h00, 8'h00, 8'h00);
        check("R4 volatile permission set", 64'(vsr_wen), 64'd1);
        check("R4 latch untouched by 50h", 64'(wel), 64'd0);
        send(2, 8'h01, 8'h3C, 8'h00, 8'h00, 8'h00);
        check("R4 status write allowed", 64'(l_allowed), 64'd1);
        check("R4 permission cleared", 64'(vsr_wen), 64'd0);
    endtask

    task automatic t_security();
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        send(4, 8'h44, 8'h00, 8'h20, 8'h00, 8'h00);
        check("R11 erase reg 2 sel", 64'(l_sec), 64'd2);
        check("R11 erase reg 2 allowed", 64'(l_allowed), 64'd1);
        check("R5 sec erase kind", 64'(l_kind), 64'd6);
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        send(5, 8'h42, 8'h01, 8'h30, 8'h07, 8'hAA);
        check("R11 bad high byte sel", 64'(l_sec), 64'd0);
        check("R11 bad high byte refused", 64'(l_allowed), 64'd0);
        check("R6 latch kept on refusal", 64'(wel), 64'd1);
        send(5, 8'h42, 8'h00, 8'h10, 8'h07, 8'hAA);
        check("R11 program reg 1 sel", 64'(l_sec), 64'd1);
        check("R5 sec program kind", 64'(l_kind), 64'd7);
        check("R11 program reg 1 allowed", 64'(l_allowed), 64'd1);
    endtask

    task automatic t_unknown();
        int c0;
        send(1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
        c0 = stb_cnt;
        oe_seen = 1'b0;
        send(5, 8'hAA, 8'h00, 8'h10, 8'h00, 8'h00);
        check("R13 unknown no strobe", 64'(stb_cnt - c0), 64'd0);
        check("R13 unknown no output", 64'(oe_seen), 64'd0);
        check("R13 unknown latch kept", 64'(wel), 64'd1);
        check("R13 unknown vsr kept", 64'(vsr_wen), 64'd0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #3ns;
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #3ns;
        t_reset();
        t_id_reads();
        t_wren();
        t_erase();
        t_wrsr();
        t_security();
        t_unknown();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule